// File: doc/BRIEF.md
# Coin Credit Vend Controller

A synchronous Moore controller for a single-price gum dispenser. One coin slot reports a nickel or a dime with a one-cycle pulse. The controller keeps the running credit in a two-bit state register. Once the credit reaches the 15-cent price, it raises `vend_open`. Change is never returned. Any credit above the price, such as two dimes, counts the same as exactly 15 cents.

After `vend_open` rises it stays high while no coin arrives. Further coins also leave it high. Only a synchronous reset clears it. The surrounding system resets the controller after each sale. It must never pulse both coin inputs in the same cycle.

Top module: `vend_fsm`

## Requirements
- R1: A synchronous, active-high `rst` sets credit to 0 cents at the next rising edge, so `vend_open` reads 0 after that edge. Reset wins over any coin pulse in the same cycle.
- R2: The credit state is encoded as 0 cents = 2'b00, 5 = 2'b01, 10 = 2'b10 and 15+ = 2'b11, and it changes only on a rising clock edge.
- R3: A nickel pulse adds 5 cents to the credit: 0 to 5, 5 to 10, and 10 to 15+.
- R4: A dime pulse adds 10 cents, saturating at 15+: 0 to 10, 5 to 15+, and 10 to 15+.
- R5: In a cycle with no coin pulse, the credit holds.
- R6: The 15+ state absorbs every further coin, and `vend_open` stays high until reset.
- R7: `vend_open` is a Moore output, high exactly when the state is 2'b11. It does not depend on the current coin inputs.
- R8: Each of these sequences raises `vend_open` on the edge that samples its last coin: N,N,N; N,D; D,N; N,N,D; D,D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| coin_nickel | input | 1 | One-cycle pulse for a 5-cent coin |
| coin_dime | input | 1 | One-cycle pulse for a 10-cent coin |
| vend_open | output | 1 | Credit has reached 15 cents |

## Verification
The bench targets these corner cases:
- **Dime in the 10-cent state.** A design that wrapped or held the credit would leave `vend_open` low after two dimes.
- **Dime in the 5-cent state.** A design that added only 5 cents would stop at 10.
- **Idle gaps between coins.** A design that drifted would reach the price early or lose credit.
- **Coins after the sale.** A design that fell out of the 15+ state would drop `vend_open`.
- **Reset together with a coin.** A design that gave the coin priority would end in a nonzero state.
- **Output timing.** `vend_open` is sampled midway through each cycle, so a Mealy-style output driven by the coin input itself would show up as early assertion.

// File: rtl/vend_fsm.sv
module vend_fsm (
  input  logic clk,
  input  logic rst,
  input  logic coin_nickel,
  input  logic coin_dime,
  output logic vend_open
);
  logic [1:0] credit_q;
  logic [1:0] credit_d;

  assign credit_d[1] = credit_q[1] | coin_dime | (credit_q[0] & coin_nickel);
  assign credit_d[0] = (coin_nickel & ~credit_q[0]) | (credit_q[0] & ~coin_nickel)
                     | (credit_q[1] & coin_nickel) | (credit_q[1] & coin_dime);

  always_ff @(posedge clk) begin
    if (rst) credit_q <= 2'b00;
    else     credit_q <= credit_d;
  end

  assign vend_open = &credit_q;

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !vend_open); // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!coin_nickel && !coin_dime) |=> $stable(credit_q)); // R5
  AST_SALE_STICKS: assert property (@(posedge clk) disable iff (rst)
    vend_open |=> vend_open); // R6
  AST_NICKEL_STEP: assert property (@(posedge clk) disable iff (rst)
    (coin_nickel && !coin_dime && credit_q != 2'b11) |=> credit_q == $past(credit_q) + 2'd1); // R3
  AST_DIME_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
    (coin_dime && !coin_nickel && credit_q == 2'b00) |=> credit_q == 2'b10); // R4
  AST_DIME_SATURATES: assert property (@(posedge clk) disable iff (rst)
    (coin_dime && !coin_nickel && credit_q != 2'b00) |=> vend_open); // R4
endmodule

// File: tb/vend_fsm_test.sv
module vend_fsm_test;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst = 1, coin_nickel = 0, coin_dime = 0;
  logic vend_open;
  int checks = 0, failures = 0;
  int model = 0;
  bit done = 0;

  vend_fsm uut (.clk(clk), .rst(rst), .coin_nickel(coin_nickel),
                .coin_dime(coin_dime), .vend_open(vend_open));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) model = 0;
    else if (coin_nickel) model = (model + 5 > 15) ? 15 : model + 5;
    else if (coin_dime) model = (model + 10 > 15) ? 15 : model + 10;
  end

  task automatic check(input string req, input logic exp);
    checks++;
    if (vend_open !== exp) begin
      failures++;
      $display("FAIL %s: vend_open=%b expected=%b", req, vend_open, exp);
    end
  endtask

  always @(negedge clk) if (!done) check("R7", model >= 15);

  task automatic step(input logic r, input logic n, input logic d);
    rst = r; coin_nickel = n; coin_dime = d;
    @(posedge clk); #1;
    rst = 0; coin_nickel = 0; coin_dime = 0;
  endtask

  task automatic run_seq(input string seq, input string req);
    step(1, 0, 0);
    check("R1", 0);
    foreach (seq[i]) begin
      if (i == seq.len() - 1) check(req, 0);
      step(0, seq[i] == "N", seq[i] == "D");
    end
    check(req, 1);
    step(0, 0, 0);
    check("R6", 1);
    step(0, 1, 0);
    check("R6", 1);
    step(0, 0, 1);
    check("R6", 1);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    failures++;
    $display("FAIL watchdog: timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(1, 0, 0); step(1, 0, 0);
    check("R1", 0);
    run_seq("NNN", "R8");
    run_seq("ND", "R8");
    run_seq("DN", "R8");
    run_seq("NND", "R8");
    run_seq("DD", "R8");
    run_seq("NNN", "R3");
    run_seq("ND", "R4");
    run_seq("DD", "R4");
    step(1, 0, 0);
    step(0, 1, 0);
    repeat (5) step(0, 0, 0);
    check("R5", 0);
    step(0, 1, 0);
    repeat (3) step(0, 0, 0);
    check("R5", 0);
    step(0, 1, 0);
    check("R3", 1);
    step(1, 0, 1);
    check("R1", 0);
    step(1, 1, 0);
    check("R1", 0);
    step(0, 1, 0);
    check("R2", 0);
    step(0, 0, 1);
    check("R2", 1);
    step(0, 0, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule